// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the hardware steps a 16-bit processor takes when it enters or leaves an interrupt. A software interrupt, a hardware interrupt or a return request starts a fixed multi-cycle sequence. During that sequence the block drives the stack-memory port, the slot-0 MMU descriptor port and the write strobes of the PC, PS and supervisor stack pointer registers. It holds a busy output high for the whole sequence so that instruction fetch stalls.

Entry first marks the processor busy by setting the Q bit in PS. It pushes PC and then PS, enters supervisor mode, and pushes both descriptor words of MMU slot 0. It then remaps slot 0 to bank 0 in ROM or RAM, as the PS R bit selects. Last, it loads PC from the vector table at the base of slot 0. Return pops those items in reverse order and clears Q as its final act. No general-purpose register is touched.

The stack grows downward: a push decrements and then writes, and a pop reads and then increments. The registers themselves live outside the block. The block reads their current values and issues registered write strobes.

Top module: `trap_sequencer`

## Requirements
- R1: After synchronous reset, busy is low and no memory, MMU, PC, PS or stack-pointer write strobe is active.
- R2: The first action of entry writes PS with Q (bit 12) set, and that PS value, with S unchanged, is the one pushed.
- R3: Entry pushes PC to address SSP-1 and PS to SSP-2. It then writes PS with S (bit 15) also set and leaves SSP at its entry value minus 4.
- R4: Entry pushes slot-0 descriptor word 0 to SSP-3 and word 1 to SSP-4.
- R5: Entry writes slot-0 word 0 to 0x0000. It writes word 1 to 0x8000 (ROM) when PS bit 11 (R) is clear and to 0x0000 (RAM) when it is set.
- R6: Entry loads PC from memory address equal to the cause code: hardware line i gives code i, and the software interrupt gives code NUM_HW.
- R7: Return pops descriptor word 1, then word 0, then PS, then PC. It restores slot 0, PS and PC from those words and returns SSP to its value before entry.
- R8: Q stays set for every cycle that busy is high during return and is cleared by the last write of the sequence, after PC is restored.
- R9: The software interrupt is taken whatever the I bit (bit 10) holds. A hardware request that arrives while I is clear is dropped and is not taken later when I is set.
- R10: A hardware request that arrives while Q is set is held until Q clears. Among held requests, the lowest line number is taken first.
- R11: Busy is high for exactly 11 cycles on entry and exactly 7 cycles on return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swi_req | input | 1 | One-cycle software interrupt request |
| ret_req | input | 1 | One-cycle return-from-interrupt request |
| hw_irq | input | NUM_HW | Hardware request pulses, line 0 highest priority |
| pc_i | input | DATA_W | Current PC |
| ps_i | input | DATA_W | Current PS |
| ssp_i | input | DATA_W | Current supervisor stack pointer |
| pc_we | output | 1 | PC write strobe |
| pc_wd | output | DATA_W | PC write value |
| ps_we | output | 1 | PS write strobe |
| ps_wd | output | DATA_W | PS write value |
| ssp_we | output | 1 | Stack pointer write strobe |
| ssp_wd | output | DATA_W | Stack pointer write value |
| mem_we | output | 1 | Stack memory write |
| mem_re | output | 1 | Stack memory read, data valid one cycle after it is sampled |
| mem_addr | output | DATA_W | Stack memory address |
| mem_wd | output | DATA_W | Stack memory write data |
| mem_rdata | input | DATA_W | Stack memory read data |
| mmu_idx | output | 1 | Slot-0 descriptor word select |
| mmu_we | output | 1 | Slot-0 descriptor write |
| mmu_wd | output | DATA_W | Slot-0 descriptor write data |
| mmu_rdata | input | DATA_W | Selected slot-0 descriptor word, combinational |
| busy | output | 1 | Sequence in progress, fetch must stall |

## Verification
Busy rises at the clock edge that samples a software or return request. For a hardware pulse it rises one edge later, because the pulse is first latched as pending. Busy then stays high for 11 or 7 cycles, and the bench counts it on falling edges. Register values are compared one full cycle after busy falls, which allows for the registered strobe and the external register behind it. The Q bit is compared one cycle later again, since the clearing write is the last strobe. Held and masked requests are judged by watching busy for a fixed window of falling-edge samples.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // PS field positions (decoded by the rest of the core)
  localparam int PS_SUP = 15;
  localparam int PS_BSY = 12;
  localparam int PS_RAM = 11;
  localparam int PS_IEN = 10;
  // slot-0 descriptor word 1 flag marking the bank as ROM
  localparam logic [15:0] DESC_ROM = 16'h8000;

  typedef enum logic [4:0] {
    ST_IDLE,
    EN_QSET, EN_PUSH_PC, EN_PUSH_PS, EN_SUP, EN_PUSH_D0, EN_PUSH_D1,
    EN_MAP0, EN_MAP1, EN_VEC, EN_VWAIT, EN_LOAD,
    RT_POP_D1, RT_POP_D0, RT_POP_PS, RT_POP_PC, RT_SET_PS, RT_SET_PC, RT_QCLR
  } seq_state_e;
endpackage

// File: rtl/trap_irq_arb.sv
module trap_irq_arb #(
  parameter int NUM_HW = 4,
  localparam int CW = $clog2(NUM_HW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_HW-1:0] irq,
  input  logic              ien,
  input  logic              take,
  output logic              any,
  output logic [CW-1:0]     cause
);
  logic [NUM_HW-1:0] pend_q;
  logic [NUM_HW-1:0] grant;
  logic [NUM_HW:0]   below;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < NUM_HW; g++) begin : g_pri
    assign grant[g]     = pend_q[g] & ~below[g];
    assign below[g + 1] = below[g] | pend_q[g];
  end
  assign any = below[NUM_HW];

  always_comb begin
    cause = '0;
    for (int i = NUM_HW - 1; i >= 0; i--)
      if (pend_q[i]) cause = CW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else pend_q <= (pend_q & ~(take ? grant : '0)) | (ien ? irq : '0);
  end

  // R10: at most one pending line is granted
  assert_one_grant_R10: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  // R10: a taken request leaves pending one cycle later
  assert_take_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (take && !(ien && |irq)) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_HW = 4,
  localparam int CW = $clog2(NUM_HW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swi_req,
  input  logic              ret_req,
  input  logic              hw_any,
  input  logic [CW-1:0]     hw_cause,
  output logic              hw_take,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] ps_i,
  input  logic [DATA_W-1:0] ssp_i,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_wd,
  output logic              ps_we,
  output logic [DATA_W-1:0] ps_wd,
  output logic              ssp_we,
  output logic [DATA_W-1:0] ssp_wd,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mmu_idx,
  output logic              mmu_we,
  output logic [DATA_W-1:0] mmu_wd,
  input  logic [DATA_W-1:0] mmu_rdata,
  output logic              busy
);
  localparam logic [CW-1:0] SWI_CAUSE = CW'(NUM_HW);
  localparam logic [DATA_W-1:0] Q_MASK = DATA_W'(1) << PS_BSY;
  localparam logic [DATA_W-1:0] S_MASK = DATA_W'(1) << PS_SUP;

  seq_state_e        state;
  logic [CW-1:0]     cause_r;
  logic [DATA_W-1:0] pc_r, ps_r, sp_r;
  logic [DATA_W-1:0] sp_dn;

  assign sp_dn   = sp_r - 1'b1;
  assign hw_take = (state == ST_IDLE) && !swi_req && !ret_req && hw_any
                   && ps_i[PS_IEN] && !ps_i[PS_BSY];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; busy <= 1'b0; cause_r <= '0;
      pc_r <= '0; ps_r <= '0; sp_r <= '0;
      pc_we <= 1'b0; pc_wd <= '0; ps_we <= 1'b0; ps_wd <= '0;
      ssp_we <= 1'b0; ssp_wd <= '0;
      mem_we <= 1'b0; mem_re <= 1'b0; mem_addr <= '0; mem_wd <= '0;
      mmu_idx <= 1'b0; mmu_we <= 1'b0; mmu_wd <= '0;
    end else begin
      pc_we <= 1'b0; ps_we <= 1'b0; ssp_we <= 1'b0;
      mem_we <= 1'b0; mem_re <= 1'b0; mmu_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          pc_r <= pc_i; ps_r <= ps_i; sp_r <= ssp_i;
          if (swi_req) begin
            cause_r <= SWI_CAUSE; busy <= 1'b1; state <= EN_QSET;
          end else if (ret_req) begin
            busy <= 1'b1; state <= RT_POP_D1;
          end else if (hw_take) begin
            cause_r <= hw_cause; busy <= 1'b1; state <= EN_QSET;
          end
        end
        // ---------------- entry ----------------
        EN_QSET: begin
          ps_r <= ps_r | Q_MASK; ps_we <= 1'b1; ps_wd <= ps_r | Q_MASK;
          state <= EN_PUSH_PC;
        end
        EN_PUSH_PC: begin
          mem_we <= 1'b1; mem_addr <= sp_dn; mem_wd <= pc_r; sp_r <= sp_dn;
          state <= EN_PUSH_PS;
        end
        EN_PUSH_PS: begin
          mem_we <= 1'b1; mem_addr <= sp_dn; mem_wd <= ps_r; sp_r <= sp_dn;
          state <= EN_SUP;
        end
        EN_SUP: begin
          ps_r <= ps_r | S_MASK; ps_we <= 1'b1; ps_wd <= ps_r | S_MASK;
          mmu_idx <= 1'b0; state <= EN_PUSH_D0;
        end
        EN_PUSH_D0: begin
          mem_we <= 1'b1; mem_addr <= sp_dn; mem_wd <= mmu_rdata; sp_r <= sp_dn;
          mmu_idx <= 1'b1; state <= EN_PUSH_D1;
        end
        EN_PUSH_D1: begin
          mem_we <= 1'b1; mem_addr <= sp_dn; mem_wd <= mmu_rdata; sp_r <= sp_dn;
          state <= EN_MAP0;
        end
        EN_MAP0: begin
          mmu_we <= 1'b1; mmu_idx <= 1'b0; mmu_wd <= '0; state <= EN_MAP1;
        end
        EN_MAP1: begin
          mmu_we <= 1'b1; mmu_idx <= 1'b1;
          mmu_wd <= ps_r[PS_RAM] ? '0 : DATA_W'(DESC_ROM);
          state <= EN_VEC;
        end
        EN_VEC: begin
          mem_re <= 1'b1; mem_addr <= DATA_W'(cause_r); state <= EN_VWAIT;
        end
        EN_VWAIT: state <= EN_LOAD;
        EN_LOAD: begin
          pc_we <= 1'b1; pc_wd <= mem_rdata;
          ssp_we <= 1'b1; ssp_wd <= sp_r;
          busy <= 1'b0; state <= ST_IDLE;
        end
        // ---------------- return ----------------
        RT_POP_D1: begin
          mem_re <= 1'b1; mem_addr <= sp_r; sp_r <= sp_r + 1'b1;
          state <= RT_POP_D0;
        end
        RT_POP_D0: begin
          mem_re <= 1'b1; mem_addr <= sp_r; sp_r <= sp_r + 1'b1;
          state <= RT_POP_PS;
        end
        RT_POP_PS: begin
          mem_re <= 1'b1; mem_addr <= sp_r; sp_r <= sp_r + 1'b1;
          mmu_we <= 1'b1; mmu_idx <= 1'b1; mmu_wd <= mem_rdata;
          state <= RT_POP_PC;
        end
        RT_POP_PC: begin
          mem_re <= 1'b1; mem_addr <= sp_r; sp_r <= sp_r + 1'b1;
          mmu_we <= 1'b1; mmu_idx <= 1'b0; mmu_wd <= mem_rdata;
          state <= RT_SET_PS;
        end
        RT_SET_PS: begin
          ps_r <= mem_rdata; ps_we <= 1'b1; ps_wd <= mem_rdata;
          state <= RT_SET_PC;
        end
        RT_SET_PC: begin
          pc_we <= 1'b1; pc_wd <= mem_rdata; state <= RT_QCLR;
        end
        RT_QCLR: begin
          ps_we <= 1'b1; ps_wd <= ps_r & ~Q_MASK;
          ssp_we <= 1'b1; ssp_wd <= sp_r;
          busy <= 1'b0; state <= ST_IDLE;
        end
        default: begin
          busy <= 1'b0; state <= ST_IDLE;
        end
      endcase
    end
  end

  // R1: stack memory is written only inside a sequence
  assert_mem_in_seq_R1: assert property (@(posedge clk) disable iff (rst) mem_we |-> busy);
  // R5: slot-0 descriptors change only inside a sequence
  assert_mmu_in_seq_R5: assert property (@(posedge clk) disable iff (rst) mmu_we |-> busy);
  // R8: a PS write with Q clear appears only once busy has dropped
  assert_q_last_R8: assert property (@(posedge clk) disable iff (rst)
    (ps_we && !ps_wd[PS_BSY]) |-> !busy);
  // R3: the stack pointer is committed as busy falls
  assert_ssp_commit_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ssp_we);
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer #(
  parameter int DATA_W = 16,
  parameter int NUM_HW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swi_req,
  input  logic              ret_req,
  input  logic [NUM_HW-1:0] hw_irq,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] ps_i,
  input  logic [DATA_W-1:0] ssp_i,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_wd,
  output logic              ps_we,
  output logic [DATA_W-1:0] ps_wd,
  output logic              ssp_we,
  output logic [DATA_W-1:0] ssp_wd,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mmu_idx,
  output logic              mmu_we,
  output logic [DATA_W-1:0] mmu_wd,
  input  logic [DATA_W-1:0] mmu_rdata,
  output logic              busy
);
  localparam int CW = $clog2(NUM_HW + 1);

  logic          hw_any, hw_take;
  logic [CW-1:0] hw_cause;

  trap_irq_arb #(.NUM_HW(NUM_HW)) u_arb (
    .clk(clk), .rst(rst), .irq(hw_irq), .ien(ps_i[trap_pkg::PS_IEN]),
    .take(hw_take), .any(hw_any), .cause(hw_cause)
  );

  trap_seq_fsm #(.DATA_W(DATA_W), .NUM_HW(NUM_HW)) u_fsm (
    .clk(clk), .rst(rst), .swi_req(swi_req), .ret_req(ret_req),
    .hw_any(hw_any), .hw_cause(hw_cause), .hw_take(hw_take),
    .pc_i(pc_i), .ps_i(ps_i), .ssp_i(ssp_i),
    .pc_we(pc_we), .pc_wd(pc_wd), .ps_we(ps_we), .ps_wd(ps_wd),
    .ssp_we(ssp_we), .ssp_wd(ssp_wd),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wd(mem_wd),
    .mem_rdata(mem_rdata), .mmu_idx(mmu_idx), .mmu_we(mmu_we), .mmu_wd(mmu_wd),
    .mmu_rdata(mmu_rdata), .busy(busy)
  );
endmodule

// File: tb/tb_trap_sequencer.sv
module tb_trap_sequencer;
  localparam int DW = 16;
  localparam int NH = 4;
  localparam logic [15:0] QM = 16'h1000, SM = 16'h8000, RM = 16'h0800, IM = 16'h0400;
  localparam logic [15:0] SSP0 = 16'h00F0;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic swi_req = 0, ret_req = 0;
  logic [NH-1:0] hw_irq = '0;
  logic pc_we, ps_we, ssp_we, mem_we, mem_re, mmu_idx, mmu_we, busy;
  logic [DW-1:0] pc_wd, ps_wd, ssp_wd, mem_addr, mem_wd, mmu_wd;
  logic [DW-1:0] mem_rdata, mmu_rdata;
  logic [DW-1:0] pc_reg, ps_reg, ssp_reg;
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] mmu [0:1];

  logic ld = 0;
  logic [DW-1:0] ld_pc, ld_ps, ld_ssp, ld_m0, ld_m1;

  function automatic logic [15:0] vec(int c);
    return 16'h1000 + 16'(c) * 16'h0111;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= (i <= NH) ? vec(i) : 16'h0;
      pc_reg <= 0; ps_reg <= 0; ssp_reg <= SSP0; mmu[0] <= 0; mmu[1] <= 0;
      mem_rdata <= 0;
    end else if (ld) begin
      pc_reg <= ld_pc; ps_reg <= ld_ps; ssp_reg <= ld_ssp;
      mmu[0] <= ld_m0; mmu[1] <= ld_m1;
    end else begin
      if (pc_we) pc_reg <= pc_wd;
      if (ps_we) ps_reg <= ps_wd;
      if (ssp_we) ssp_reg <= ssp_wd;
      if (mmu_we) mmu[mmu_idx] <= mmu_wd;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wd;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end
  end
  assign mmu_rdata = mmu[mmu_idx];

  trap_sequencer #(.DATA_W(DW), .NUM_HW(NH)) dut (
    .clk(clk), .rst(rst), .swi_req(swi_req), .ret_req(ret_req), .hw_irq(hw_irq),
    .pc_i(pc_reg), .ps_i(ps_reg), .ssp_i(ssp_reg),
    .pc_we(pc_we), .pc_wd(pc_wd), .ps_we(ps_we), .ps_wd(ps_wd),
    .ssp_we(ssp_we), .ssp_wd(ssp_wd), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wd(mem_wd), .mem_rdata(mem_rdata),
    .mmu_idx(mmu_idx), .mmu_we(mmu_we), .mmu_wd(mmu_wd), .mmu_rdata(mmu_rdata),
    .busy(busy)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic load(logic [15:0] p, logic [15:0] s, logic [15:0] m0, logic [15:0] m1);
    ld_pc = p; ld_ps = s; ld_ssp = SSP0; ld_m0 = m0; ld_m1 = m1; ld = 1;
    @(negedge clk); ld = 0; @(negedge clk);
  endtask

  task automatic wait_busy(output bit seen);
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      if (busy) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  // counts busy-high cycles; qall reports whether Q stayed set throughout
  task automatic count_busy(output int n, output bit qall);
    n = 0; qall = 1;
    while (busy && n < 100) begin
      if (!ps_reg[12] && n > 0) qall = 0;
      n++; @(negedge clk);
    end
  endtask

  task automatic pulse_swi(); swi_req = 1; @(negedge clk); swi_req = 0; endtask
  task automatic pulse_ret(); ret_req = 1; @(negedge clk); ret_req = 0; endtask
  task automatic pulse_hw(int l); hw_irq[l] = 1; @(negedge clk); hw_irq = '0; endtask

  // entry checks after busy seen high; values from the requirements
  task automatic check_entry(string t, logic [15:0] p, logic [15:0] s,
                             logic [15:0] m0, logic [15:0] m1, int c);
    int n; bit q, seen;
    wait_busy(seen);
    check({t, " R11 entry started"}, 32'(seen), 1);
    count_busy(n, q);
    check({t, " R11 entry length"}, n, 11);
    @(negedge clk);
    check({t, " R3 pc pushed"}, mem[8'hEF], p);
    check({t, " R2 ps pushed with Q"}, mem[8'hEE], s | QM);
    check({t, " R4 desc0 pushed"}, mem[8'hED], m0);
    check({t, " R4 desc1 pushed"}, mem[8'hEC], m1);
    check({t, " R3 ssp"}, ssp_reg, SSP0 - 4);
    check({t, " R3 ps after entry"}, ps_reg, s | QM | SM);
    check({t, " R5 slot0 word0"}, mmu[0], 0);
    check({t, " R5 slot0 word1"}, mmu[1], (s & RM) != 0 ? 16'h0000 : 16'h8000);
    check({t, " R6 vector pc"}, pc_reg, vec(c));
  endtask

  task automatic check_return(string t, logic [15:0] p, logic [15:0] s,
                              logic [15:0] m0, logic [15:0] m1);
    int n; bit q;
    pulse_ret();
    check({t, " R11 return started"}, 32'(busy), 1);
    count_busy(n, q);
    check({t, " R11 return length"}, n, 7);
    check({t, " R8 Q held while busy"}, 32'(q), 1);
    check({t, " R8 Q set at busy fall"}, 32'(ps_reg[12]), 1);
    check({t, " R7 pc restored before Q clear"}, pc_reg, p);
    @(negedge clk);
    check({t, " R8 Q cleared"}, 32'(ps_reg[12]), 0);
    check({t, " R7 ps restored"}, ps_reg, s);
    check({t, " R7 ssp restored"}, ssp_reg, SSP0);
    check({t, " R7 desc0 restored"}, mmu[0], m0);
    check({t, " R7 desc1 restored"}, mmu[1], m1);
  endtask

  initial begin
    bit seen;
    int n; bit q;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 busy after reset", 32'(busy), 0);
    check("R1 strobes after reset", {28'h0, mem_we, mmu_we, pc_we, ps_we}, 0);
    @(negedge clk);

    // sweep: every hardware line, both ROM/RAM choices
    for (int l = 0; l < NH; l++) begin
      for (int r = 0; r < 2; r++) begin
        logic [15:0] p, s, m0, m1;
        p = 16'h2000 + 16'(l * 16 + r);
        s = IM | (r != 0 ? RM : 16'h0) | ((l % 2) != 0 ? SM : 16'h0) | 16'h0003;
        m0 = 16'h0030 + 16'(l); m1 = 16'h4000 | 16'(l * 2 + r);
        load(p, s, m0, m1);
        pulse_hw(l);
        check_entry($sformatf("hw%0d r%0d", l, r), p, s, m0, m1, l);
        check_return($sformatf("hw%0d r%0d", l, r), p, s, m0, m1);
      end
    end

    // R9: software interrupt with interrupts disabled
    load(16'h3456, 16'h0001, 16'h0077, 16'h0001);
    pulse_swi();
    check_entry("swi masked R9", 16'h3456, 16'h0001, 16'h0077, 16'h0001, NH);
    check_return("swi masked R9", 16'h3456, 16'h0001, 16'h0077, 16'h0001);

    // R9: hardware request while I clear is dropped
    load(16'h0100, 16'h0000, 16'h0011, 16'h0022);
    pulse_hw(2);
    seen = 0;
    for (int k = 0; k < 20; k++) begin if (busy) seen = 1; @(negedge clk); end
    check("R9 masked hw not taken", 32'(seen), 0);
    load(16'h0100, IM, 16'h0011, 16'h0022);
    for (int k = 0; k < 20; k++) begin if (busy) seen = 1; @(negedge clk); end
    check("R9 masked hw not latched", 32'(seen), 0);
    check("R9 pc untouched", pc_reg, 16'h0100);

    // R10: requests during a sequence are held, lowest line first
    load(16'h0555, IM, 16'h0044, 16'h0088);
    swi_req = 1; @(negedge clk); swi_req = 0;
    @(negedge clk); @(negedge clk);
    hw_irq = 4'b1010; @(negedge clk); hw_irq = '0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R10 swi vector", pc_reg, vec(NH));
    seen = 0;
    for (int k = 0; k < 12; k++) begin if (busy) seen = 1; @(negedge clk); end
    check("R10 held while Q set", 32'(seen), 0);
    pulse_ret();
    while (busy) @(negedge clk);
    wait_busy(seen);
    check("R10 held request taken after Q clear", 32'(seen), 1);
    count_busy(n, q);
    check("R10 nested entry length", n, 11);
    @(negedge clk);
    check("R10 lowest line first", pc_reg, vec(1));
    pulse_ret();
    while (busy) @(negedge clk);
    wait_busy(seen);
    count_busy(n, q);
    @(negedge clk);
    check("R10 second held line", pc_reg, vec(3));
    check_return("R10 final", 16'h0555, IM, 16'h0044, 16'h0088);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule